// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine

This block computes a 16-bit cyclic redundancy check over a stream of bytes that software writes, one per access, through a small 16-bit register window. It is meant for building or checking the frame check sequence of slow infrared serial frames. Each byte folds into the running checksum in the same clock as the write, and a 12-bit counter records how many bytes have been folded since the last restart. Software restarts the engine by writing a control word with its top bit set. It then feeds bytes and reads either the raw checksum state or the finished (complemented) value.

Every register access is decoded into one of three operations, and these are the engine's only states of activity. HOLD is the default: no write, or a write that changes nothing. CLEAR comes from a control write with bit 15 set, and it moves the checksum to its preset and the counter to zero. FOLD comes from a write to the data-input register, and it moves the checksum to its next value and the counter up by one. After every operation the engine returns to HOLD unless the next cycle carries another write. The default arithmetic is the bit-reflected CCITT polynomial 0x8408, processed least significant bit first, with a preset of 0xFFFF. Parameters select the polynomial, the preset, the bit order and whether the finished value is complemented.

Top module: `crc16_byte_engine`

## Requirements
- R1: After rst_n is released, the count reads 0, the raw-state register reads the preset (0xFFFF by default) and the finished register reads its complement (0x0000 by default).
- R2: A write to offset 0x2 folds bits 7:0 of the write data into the checksum in one clock and raises the count by one. Bits 15:8 of that write have no effect. The result equals a bit-serial model: XOR the byte into the low bits, then for each of 8 steps shift right one place and XOR 0x8408 when the bit shifted out was 1.
- R3: A write to offset 0x0 with bit 15 set returns the checksum to the preset and the count to 0. A read of offset 0x0 returns the count in bits 11:0 and 0 in bits 15:12.
- R4: A write to offset 0x0 with bit 15 clear changes neither the checksum nor the count.
- R5: The 12-bit count wraps from 0xFFF to 0x000 on the next fold.
- R6: A read of offset 0x4 or offset 0x6 returns the current raw checksum state. Writes to offset 0x4 are ignored.
- R7: A read of offset 0x8 returns the bitwise complement of the raw state. This is the default, with INVERT_OUT=1.
- R8: After a restart followed by the bytes 0xCC, 0xF5, 0xF1, 0xA7, the count reads 4 and the finished register matches the R2 model complemented.
- R9: Offsets 0x2 and every address other than 0x0, 0x4, 0x6 and 0x8 read as 0. Writes to offsets 0x6 and 0x8 and to unmapped addresses change nothing.
- R10: Reads are combinational from the stored state. A read in the same cycle as a write returns the value from before that write, and the new value appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Write strobe for the current address, one write per high cycle |
| reg_addr | input | ADDR_W (4) | Byte offset of the register accessed |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |

## Verification
The operation that collides with a read is the restart. A control write with bit 15 set and a readback of the count occupy the same cycle whenever software reads the control register while clearing it. The bench provokes this by holding a clearing write at offset 0x0 after a run of folded bytes, sampling reg_rdata before the clock edge, and sampling it again afterwards. The old nonzero count must appear first and zero must follow. Fold results are judged against a bit-serial model in the bench, across a sweep of all 256 byte values from the preset, a long chained stream and a full counter wrap.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;

    // operation decoded from one register access
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_FOLD  = 2'd2
    } crc_op_e;

    // register selected by the address
    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_DIN  = 3'd1,
        SEL_CALC = 3'd2,
        SEL_RAW  = 3'd3,
        SEL_FIN  = 3'd4,
        SEL_NONE = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/crc16_decode.sv
module crc16_decode
    import crc16_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output reg_sel_e          sel,
    output crc_op_e           op,
    output logic [BYTE_W-1:0] byte_in
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CALC = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_FIN  = ADDR_W'(8);
    localparam int                CLR_BIT = BUS_W - 1;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^reg_wdata[CLR_BIT-1:BYTE_W];

    assign byte_in = reg_wdata[BYTE_W-1:0];

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  sel = SEL_CTRL;
            A_DIN:   sel = SEL_DIN;
            A_CALC:  sel = SEL_CALC;
            A_RAW:   sel = SEL_RAW;
            A_FIN:   sel = SEL_FIN;
            default: sel = SEL_NONE;
        endcase
    end

    always_comb begin
        op = OP_HOLD;
        if (reg_wen) begin
            unique case (sel)
                SEL_CTRL: op = reg_wdata[CLR_BIT] ? OP_CLEAR : OP_HOLD;
                SEL_DIN:  op = OP_FOLD;
                default:  op = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/crc16_fold.sv
module crc16_fold
    import crc16_pkg::*;
#(
    parameter int             CRC_W   = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h8408,
    parameter bit             REFLECT = 1'b1
) (
    input  logic [CRC_W-1:0]  state_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  state_out
);

    generate
        if (REFLECT) begin : g_lsb_first
            logic [CRC_W-1:0] acc;
            always_comb begin
                acc = state_in ^ {{(CRC_W-BYTE_W){1'b0}}, byte_in};
                for (int i = 0; i < BYTE_W; i++) begin
                    if (acc[0]) acc = (acc >> 1) ^ POLY;
                    else        acc = acc >> 1;
                end
                state_out = acc;
            end
        end else begin : g_msb_first
            logic [CRC_W-1:0] acc;
            always_comb begin
                acc = state_in ^ {byte_in, {(CRC_W-BYTE_W){1'b0}}};
                for (int i = 0; i < BYTE_W; i++) begin
                    if (acc[CRC_W-1]) acc = (acc << 1) ^ POLY;
                    else              acc = acc << 1;
                end
                state_out = acc;
            end
        end
    endgenerate

endmodule

// File: rtl/crc16_core.sv
module crc16_core
    import crc16_pkg::*;
#(
    parameter int               CRC_W   = 16,
    parameter int               CNT_W   = 12,
    parameter logic [CRC_W-1:0] POLY    = 16'h8408,
    parameter logic [CRC_W-1:0] PRESET  = 16'hFFFF,
    parameter bit               REFLECT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  crc_op_e           op,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_state,
    output logic [CNT_W-1:0]  byte_cnt
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CRC_W-1:0] folded;

    crc16_fold #(
        .CRC_W   (CRC_W),
        .POLY    (POLY),
        .REFLECT (REFLECT)
    ) u_fold (
        .state_in  (crc_state),
        .byte_in   (byte_in),
        .state_out (folded)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_state <= PRESET;
            byte_cnt  <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: begin
                    crc_state <= PRESET;
                    byte_cnt  <= '0;
                end
                OP_FOLD: begin
                    crc_state <= folded;
                    byte_cnt  <= byte_cnt + CNT_ONE;
                end
                default: begin
                    crc_state <= crc_state;
                    byte_cnt  <= byte_cnt;
                end
            endcase
        end
    end

    // R2
    fold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FOLD) |=> (byte_cnt == $past(byte_cnt) + CNT_ONE));

    // R3
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (crc_state == PRESET && byte_cnt == '0));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> ($stable(crc_state) && $stable(byte_cnt)));

    // R5
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FOLD && byte_cnt == CNT_TOP) |=> (byte_cnt == '0));

endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine
    import crc16_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          CNT_W      = 12,
    parameter logic [15:0] POLY       = 16'h8408,
    parameter logic [15:0] PRESET     = 16'hFFFF,
    parameter bit          REFLECT    = 1'b1,
    parameter bit          INVERT_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata
);

    localparam int          CRC_W    = BUS_W;
    localparam int          CTRL_HI  = BUS_W - CNT_W;
    localparam logic [CRC_W-1:0] OUT_MASK = INVERT_OUT ? {CRC_W{1'b1}} : '0;

    reg_sel_e          sel;
    crc_op_e           op;
    logic [BYTE_W-1:0] byte_in;
    logic [CRC_W-1:0]  crc_state;
    logic [CNT_W-1:0]  byte_cnt;
    logic [CRC_W-1:0]  crc_final;

    crc16_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sel       (sel),
        .op        (op),
        .byte_in   (byte_in)
    );

    crc16_core #(
        .CRC_W   (CRC_W),
        .CNT_W   (CNT_W),
        .POLY    (POLY),
        .PRESET  (PRESET),
        .REFLECT (REFLECT)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .byte_in   (byte_in),
        .crc_state (crc_state),
        .byte_cnt  (byte_cnt)
    );

    assign crc_final = crc_state ^ OUT_MASK;

    always_comb begin
        unique case (sel)
            SEL_CTRL: reg_rdata = {{CTRL_HI{1'b0}}, byte_cnt};
            SEL_CALC: reg_rdata = crc_state;
            SEL_RAW:  reg_rdata = crc_state;
            SEL_FIN:  reg_rdata = crc_final;
            default:  reg_rdata = '0;
        endcase
    end

    // R3
    ctrl_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> (reg_rdata[BUS_W-1:CNT_W] == '0));

    // R10
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == ADDR_W'(0) && reg_wdata[BUS_W-1] && byte_cnt != '0)
        |-> (reg_rdata != '0));

endmodule

// File: tb/crc16_byte_engine_tb.sv
module crc16_byte_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wen;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] m_state;
    int          m_cnt;

    always #5 clk = ~clk;

    crc16_byte_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [15:0] ref_fold(input logic [15:0] s, input logic [7:0] b);
        logic [15:0] a;
        a = s ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            if (a[0]) a = (a >> 1) ^ 16'h8408;
            else      a = a >> 1;
        end
        return a;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wen   = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_wen  = 1'b0;
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic feed(input logic [15:0] d);
        wr(4'h2, d);
        m_state = ref_fold(m_state, d[7:0]);
        m_cnt   = (m_cnt + 1) % 4096;
    endtask

    task automatic restart();
        wr(4'h0, 16'h8000);
        m_state = 16'hFFFF;
        m_cnt   = 0;
    endtask

    task automatic check_all(input string tag);
        logic [15:0] v;
        rd(4'h0, v); chk({tag, " count"}, v, 16'(m_cnt));
        rd(4'h4, v); chk({tag, " calc R6"}, v, m_state);
        rd(4'h6, v); chk({tag, " raw R6"}, v, m_state);
        rd(4'h8, v); chk({tag, " final R7"}, v, ~m_state);
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_state = 16'hFFFF; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_all("R1 reset");

        // R2 R7 sweep of every byte value from the preset, high byte as noise
        for (int b = 0; b < 256; b++) begin
            restart();
            feed({8'(b ^ 8'h5A), 8'(b)});
            rd(4'h6, v); chk("R2 sweep raw", v, m_state);
            rd(4'h8, v); chk("R7 sweep final", v, ~m_state);
            rd(4'h0, v); chk("R2 sweep count", v, 16'd1);
        end

        // R2 chained stream
        restart();
        for (int i = 0; i < 200; i++) begin
            feed({8'(i), 8'((i * 37 + 11) & 255)});
            rd(4'h6, v); chk("R2 chain raw", v, m_state);
        end
        check_all("R2 chain end");

        // R3 control readback upper bits
        rd(4'h0, v); chk("R3 ctrl high bits", {12'h000, v[15:12]}, 16'h0000);

        // R4 control write without the restart bit
        wr(4'h0, 16'h7FFF);
        check_all("R4 no restart");

        // R6 R9 ignored writes and unmapped reads
        wr(4'h4, 16'h1234); check_all("R6 calc write");
        wr(4'h6, 16'hBEEF); check_all("R9 raw write");
        wr(4'h8, 16'hCAFE); check_all("R9 final write");
        wr(4'hA, 16'h00AA); check_all("R9 unmapped write");
        wr(4'h3, 16'h0033); check_all("R9 odd write");
        rd(4'h2, v); chk("R9 din reads 0", v, 16'h0000);
        rd(4'hA, v); chk("R9 addr A reads 0", v, 16'h0000);
        rd(4'h1, v); chk("R9 addr 1 reads 0", v, 16'h0000);
        rd(4'hE, v); chk("R9 addr E reads 0", v, 16'h0000);

        // R10 clear and count readback in the same cycle
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 4'h0; reg_wdata = 16'h8000;
        #1;
        chk("R10 old count during clear", reg_rdata, 16'(m_cnt));
        @(posedge clk);
        #1 reg_wen = 1'b0;
        m_state = 16'hFFFF; m_cnt = 0;
        check_all("R3 after clear");

        // R8 four-byte check sequence
        restart();
        feed(16'h00CC); feed(16'h00F5); feed(16'h00F1); feed(16'h00A7);
        rd(4'h0, v); chk("R8 count", v, 16'd4);
        rd(4'h8, v); chk("R8 final", v, ~m_state);
        rd(4'h6, v); chk("R8 raw", v, m_state);

        // R5 counter wrap
        restart();
        for (int i = 0; i < 4095; i++) feed(16'(i));
        rd(4'h0, v); chk("R5 count at top", v, 16'h0FFF);
        feed(16'h0077);
        rd(4'h0, v); chk("R5 wrap to zero", v, 16'h0000);
        rd(4'h6, v); chk("R5 raw after wrap", v, m_state);
        feed(16'h0088);
        rd(4'h0, v); chk("R5 count after wrap", v, 16'h0001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule